// File: doc/BRIEF.md
# Interleaved Fetch Line Aligner

This block is the alignment stage of a sequential instruction fetch path. Each cycle it takes two consecutive 16-instruction lines from a two-bank interleaved instruction cache: the even bank holds lines whose line index is even, and the odd bank holds the rest. It also takes the per-slot branch-detect bits and target addresses that an interleaved branch target buffer read in parallel with the cache, the direction predictions for up to three branches, and the current fetch address. From these it builds a 16-slot instruction latch that holds the contiguous run starting at the fetch address, a valid mask, the next fetch address and the number of predictions that were used.

Both the bank order and the rotation amount depend only on the low bits of the fetch address, so they are ready at the start of the cycle. The run ends after the first branch that is predicted taken, or after the third branch found in the window, or at the end of the 16-slot window, whichever comes first. The swap, the barrel shift and the stop scan are combinational. The outputs are registered, so the result appears one clock after the request.

Top module: `fetch_aligner`

## Requirements
- R1: While reset is asserted (`rst_n` low) and after it is released with no request, `out_valid` is 0 and `out_mask` is all zeros.
- R2: `out_valid` is 1 exactly in the cycle after a cycle with `fetch_valid` high. After a cycle with `fetch_valid` low, `out_valid` is 0 and `out_mask` is all zeros.
- R3: Fetch address bit 4 (the line-index LSB) selects the first line. When it is 0 the even bank is first in program order; when it is 1 the odd bank is first and the even bank supplies the following line.
- R4: Output slot k holds the instruction at address fetch_addr + k (addresses count instructions), including slots that come from the following line.
- R5: When `out_valid` is 1, `out_mask` is a run of ones that starts at bit 0 with no gaps.
- R6: At the first in-window branch whose prediction is taken, the run ends in that slot and the next address is that slot's target.
- R7: If the third in-window branch is predicted not taken, the run ends in its slot and the next address is that branch's address plus 1.
- R8: If no stop occurs, all 16 mask bits are set and the next address is fetch_addr + 16. Branch-detect bits in lanes outside the 16-slot window have no effect.
- R9: `out_pred_used` equals the number of branches in the valid run (0 to 3).
- R10: Predictions are used in fetch order: bit 0 of `pred_taken` applies to the first branch in the window, bit 1 to the second, and bit 2 to the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Request valid this cycle |
| fetch_addr | input | 32 | Fetch address in instruction units |
| even_insn | input | 512 | Even bank line, slot 0 in the low bits |
| odd_insn | input | 512 | Odd bank line |
| even_br | input | 16 | Branch-detect bits per even bank slot |
| odd_br | input | 16 | Branch-detect bits per odd bank slot |
| even_tgt | input | 512 | Target address per even bank slot |
| odd_tgt | input | 512 | Target address per odd bank slot |
| pred_taken | input | 3 | Predicted directions for branches 1 to 3 in order |
| out_valid | output | 1 | Latch contents valid |
| out_insn | output | 512 | Aligned instruction latch, slot 0 in the low bits |
| out_mask | output | 16 | Valid slots of the latch |
| out_next_addr | output | 32 | Next fetch address |
| out_pred_used | output | 2 | Number of predictions used |

## Verification
The hardest case to reach is a window whose start sits near the end of an odd line, because the following line then comes from the even bank, and the branches that decide the stop lie on both sides of the line seam. Such a window also has detect bits in lanes of the two lines that fall outside it. The bench builds both bank images from one address-derived pattern, so any fetch address yields consistent lines. It places branches on chosen absolute addresses just before the window, inside it, on its last slot and just after it. It then uses chosen prediction bit patterns to move the stop among the first, second and third branch.

// File: rtl/fa_pkg.sv
package fa_pkg;
    parameter int unsigned FA_SLOTS  = 16;
    parameter int unsigned FA_INSN_W = 32;
    parameter int unsigned FA_ADDR_W = 32;
    parameter int unsigned FA_MAX_BR = 3;
endpackage

// File: rtl/fa_swap.sv
// Puts two bank lanes into program order.
module fa_swap #(
    parameter int unsigned W = 32
) (
    input  logic         odd_first,
    input  logic [W-1:0] even_in,
    input  logic [W-1:0] odd_in,
    output logic [2*W-1:0] ordered
);
    always_comb begin
        if (odd_first) ordered = {even_in, odd_in};
        else           ordered = {odd_in, even_in};
    end
endmodule

// File: rtl/fa_shifter.sv
// Logarithmic barrel shifter. It moves lane 'shamt' of a two-line window to lane 0.
module fa_shifter #(
    parameter int unsigned SLOTS = 16,
    parameter int unsigned W     = 32,
    localparam int unsigned OFF_W = $clog2(SLOTS),
    localparam int unsigned FULL  = 2 * SLOTS * W
) (
    input  logic [FULL-1:0]    win,
    input  logic [OFF_W-1:0]   shamt,
    output logic [SLOTS*W-1:0] aligned
);
    logic [FULL-1:0] stg [0:OFF_W];

    assign stg[0] = win;

    for (genvar s = 0; s < OFF_W; s++) begin : g_stage
        assign stg[s+1] = shamt[s] ? (stg[s] >> (W << s)) : stg[s];
    end

    assign aligned = stg[OFF_W][SLOTS*W-1:0];
endmodule

// File: rtl/fa_scan.sv
// Finds where the run stops, and the next address and prediction count.
module fa_scan #(
    parameter int unsigned SLOTS  = 16,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned MAX_BR = 3,
    localparam int unsigned CNT_W = $clog2(MAX_BR + 1),
    localparam int unsigned PAD   = 1 << CNT_W
) (
    input  logic [ADDR_W-1:0]       base,
    input  logic [SLOTS-1:0]        hit,
    input  logic [SLOTS*ADDR_W-1:0] tgt,
    input  logic [MAX_BR-1:0]       pred,
    output logic [SLOTS-1:0]        mask,
    output logic [ADDR_W-1:0]       next_addr,
    output logic [CNT_W-1:0]        used
);
    logic [PAD-1:0] pred_pad;
    assign pred_pad = PAD'(pred);

    always_comb begin
        logic stop;
        stop      = 1'b0;
        mask      = '0;
        used      = '0;
        next_addr = base + ADDR_W'(SLOTS);
        for (int k = 0; k < SLOTS; k++) begin
            if (!stop) begin
                mask[k] = 1'b1;
                if (hit[k]) begin
                    if (pred_pad[used]) begin
                        stop      = 1'b1;
                        next_addr = tgt[k*ADDR_W +: ADDR_W];
                    end
                    used = used + 1'b1;
                    if (!stop && used == CNT_W'(MAX_BR)) begin
                        stop      = 1'b1;
                        next_addr = base + ADDR_W'(k) + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/fetch_aligner.sv
module fetch_aligner
    import fa_pkg::*;
#(
    parameter int unsigned SLOTS  = FA_SLOTS,
    parameter int unsigned INSN_W = FA_INSN_W,
    parameter int unsigned ADDR_W = FA_ADDR_W,
    parameter int unsigned MAX_BR = FA_MAX_BR,
    localparam int unsigned OFF_W = $clog2(SLOTS),
    localparam int unsigned CNT_W = $clog2(MAX_BR + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      fetch_valid,
    input  logic [ADDR_W-1:0]         fetch_addr,
    input  logic [SLOTS*INSN_W-1:0]   even_insn,
    input  logic [SLOTS*INSN_W-1:0]   odd_insn,
    input  logic [SLOTS-1:0]          even_br,
    input  logic [SLOTS-1:0]          odd_br,
    input  logic [SLOTS*ADDR_W-1:0]   even_tgt,
    input  logic [SLOTS*ADDR_W-1:0]   odd_tgt,
    input  logic [MAX_BR-1:0]         pred_taken,
    output logic                      out_valid,
    output logic [SLOTS*INSN_W-1:0]   out_insn,
    output logic [SLOTS-1:0]          out_mask,
    output logic [ADDR_W-1:0]         out_next_addr,
    output logic [CNT_W-1:0]          out_pred_used
);
    typedef struct packed {
        logic                    valid;
        logic [SLOTS*INSN_W-1:0] insn;
        logic [SLOTS-1:0]        mask;
        logic [ADDR_W-1:0]       next_addr;
        logic [CNT_W-1:0]        used;
    } latch_t;

    latch_t st_d, st_q;

    logic                      odd_first;
    logic [OFF_W-1:0]          shamt;
    logic [2*SLOTS*INSN_W-1:0] win_insn;
    logic [2*SLOTS-1:0]        win_br;
    logic [2*SLOTS*ADDR_W-1:0] win_tgt;
    logic [SLOTS*INSN_W-1:0]   al_insn;
    logic [SLOTS-1:0]          al_br;
    logic [SLOTS*ADDR_W-1:0]   al_tgt;
    logic [SLOTS-1:0]          scan_mask;
    logic [ADDR_W-1:0]         scan_next;
    logic [CNT_W-1:0]          scan_used;

    // Bank order and shift amount depend only on the low address bits.
    assign odd_first = fetch_addr[OFF_W];
    assign shamt     = fetch_addr[OFF_W-1:0];

    fa_swap #(.W(SLOTS*INSN_W)) u_swap_insn (
        .odd_first(odd_first), .even_in(even_insn), .odd_in(odd_insn), .ordered(win_insn));
    fa_swap #(.W(SLOTS)) u_swap_br (
        .odd_first(odd_first), .even_in(even_br), .odd_in(odd_br), .ordered(win_br));
    fa_swap #(.W(SLOTS*ADDR_W)) u_swap_tgt (
        .odd_first(odd_first), .even_in(even_tgt), .odd_in(odd_tgt), .ordered(win_tgt));

    fa_shifter #(.SLOTS(SLOTS), .W(INSN_W)) u_sh_insn (
        .win(win_insn), .shamt(shamt), .aligned(al_insn));
    fa_shifter #(.SLOTS(SLOTS), .W(1)) u_sh_br (
        .win(win_br), .shamt(shamt), .aligned(al_br));
    fa_shifter #(.SLOTS(SLOTS), .W(ADDR_W)) u_sh_tgt (
        .win(win_tgt), .shamt(shamt), .aligned(al_tgt));

    fa_scan #(.SLOTS(SLOTS), .ADDR_W(ADDR_W), .MAX_BR(MAX_BR)) u_scan (
        .base(fetch_addr), .hit(al_br), .tgt(al_tgt), .pred(pred_taken),
        .mask(scan_mask), .next_addr(scan_next), .used(scan_used));

    always_comb begin
        st_d       = st_q;
        st_d.valid = fetch_valid;
        st_d.mask  = '0;
        if (fetch_valid) begin
            st_d.insn      = al_insn;
            st_d.mask      = scan_mask;
            st_d.next_addr = scan_next;
            st_d.used      = scan_used;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid     = st_q.valid;
    assign out_insn      = st_q.insn;
    assign out_mask      = st_q.mask;
    assign out_next_addr = st_q.next_addr;
    assign out_pred_used = st_q.used;
endmodule

// File: rtl/fa_checker.sv
module fa_checker #(
    parameter int unsigned SLOTS  = 16,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned MAX_BR = 3,
    localparam int unsigned CNT_W = $clog2(MAX_BR + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_valid,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              out_valid,
    input logic [SLOTS-1:0]  out_mask,
    input logic [ADDR_W-1:0] out_next_addr,
    input logic [CNT_W-1:0]  out_pred_used
);
    logic [ADDR_W-1:0] prev_addr;
    logic [ADDR_W-1:0] seq_end;

    always_ff @(posedge clk) prev_addr <= fetch_addr;
    assign seq_end = prev_addr + ADDR_W'($countones(out_mask));

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |=> out_valid);
    a_r2_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |=> (!out_valid && out_mask == '0));
    a_r1_mask_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> out_mask == '0);
    a_r5_mask_contig: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_mask[0] && ((out_mask & (out_mask + 1'b1)) == '0)));
    a_r9_used_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_pred_used <= CNT_W'(MAX_BR));
    a_r8_no_branch_seq: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_pred_used == '0) |-> (&out_mask && out_next_addr == seq_end));
    a_r6_redirect_uses_pred: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_next_addr != seq_end) |-> out_pred_used != '0);
endmodule

bind fetch_aligner fa_checker #(.SLOTS(SLOTS), .ADDR_W(ADDR_W), .MAX_BR(MAX_BR)) u_fa_checker (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .out_valid(out_valid), .out_mask(out_mask), .out_next_addr(out_next_addr),
    .out_pred_used(out_pred_used));

// File: tb/fetch_aligner_bench.sv
`timescale 1ns/1ps
module fetch_aligner_bench;
    localparam int S = 16;
    localparam int IW = 32;
    localparam int AW = 32;
    localparam logic [31:0] NONE = 32'hFFFF_FFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fetch_valid = 1'b0;
    logic [AW-1:0] fetch_addr = '0;
    logic [S*IW-1:0] even_insn = '0, odd_insn = '0;
    logic [S-1:0] even_br = '0, odd_br = '0;
    logic [S*AW-1:0] even_tgt = '0, odd_tgt = '0;
    logic [2:0] pred_taken = '0;
    logic out_valid;
    logic [S*IW-1:0] out_insn;
    logic [S-1:0] out_mask;
    logic [AW-1:0] out_next_addr;
    logic [1:0] out_pred_used;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fetch_aligner u_fetch_aligner (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .even_insn(even_insn), .odd_insn(odd_insn), .even_br(even_br), .odd_br(odd_br),
        .even_tgt(even_tgt), .odd_tgt(odd_tgt), .pred_taken(pred_taken),
        .out_valid(out_valid), .out_insn(out_insn), .out_mask(out_mask),
        .out_next_addr(out_next_addr), .out_pred_used(out_pred_used));

    function automatic logic [31:0] word_at(logic [31:0] a);
        return 32'hC000_0000 | a;
    endfunction

    function automatic logic [31:0] tgt_of(logic [31:0] a);
        return a + 32'h800;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Fill both banks for the line pair at addr; branches at b0..b2 (absolute).
    task automatic load(logic [31:0] addr, logic [31:0] b0, logic [31:0] b1, logic [31:0] b2);
        for (int l = 0; l < 2; l++) begin
            logic [31:0] lbase;
            lbase = ((addr >> 4) + 32'(l)) << 4;
            for (int s = 0; s < S; s++) begin
                logic [31:0] a;
                logic isbr;
                a = lbase + 32'(s);
                isbr = (a == b0) || (a == b1) || (a == b2);
                if (lbase[4]) begin
                    odd_insn[s*IW +: IW] = word_at(a);
                    odd_br[s] = isbr;
                    odd_tgt[s*AW +: AW] = tgt_of(a);
                end else begin
                    even_insn[s*IW +: IW] = word_at(a);
                    even_br[s] = isbr;
                    even_tgt[s*AW +: AW] = tgt_of(a);
                end
            end
        end
    endtask

    task automatic run_case(string req, logic [31:0] addr, logic [31:0] b0, logic [31:0] b1,
                            logic [31:0] b2, logic [2:0] preds, logic [15:0] exp_mask,
                            logic [31:0] exp_next, logic [1:0] exp_used);
        @(negedge clk);
        load(addr, b0, b1, b2);
        fetch_addr = addr;
        pred_taken = preds;
        fetch_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        fetch_valid = 1'b0;
        check({req, " valid"}, 32'(out_valid), 32'd1);
        check({req, " mask"}, 32'(out_mask), 32'(exp_mask));
        check({req, " next"}, out_next_addr, exp_next);
        check({req, " used R9"}, 32'(out_pred_used), 32'(exp_used));
        begin
            logic [31:0] bad_act, bad_exp;
            bit bad;
            bad = 1'b0; bad_act = '0; bad_exp = '0;
            for (int k = 0; k < S; k++) begin
                if (exp_mask[k] && !bad && out_insn[k*IW +: IW] !== word_at(addr + 32'(k))) begin
                    bad = 1'b1;
                    bad_act = out_insn[k*IW +: IW];
                    bad_exp = word_at(addr + 32'(k));
                end
            end
            // R3/R4: slot k carries the instruction at addr+k
            check({req, " R4 slots"}, bad ? bad_act : 32'd0, bad ? bad_exp : 32'd0);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 valid after reset", 32'(out_valid), 32'd0);
        check("R1 mask after reset", 32'(out_mask), 32'd0);
    endtask

    task automatic t_idle();
        @(negedge clk);
        check("R2 valid when idle", 32'(out_valid), 32'd0);
        check("R2 mask when idle", 32'(out_mask), 32'd0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        // R8: even line, no branches
        run_case("R8 even aligned", 32'h40, NONE, NONE, NONE, 3'b000, 16'hFFFF, 32'h50, 2'd0);
        // R3: odd bank first
        run_case("R3 odd first", 32'h50, NONE, NONE, NONE, 3'b000, 16'hFFFF, 32'h60, 2'd0);
        // R4 + R8: crosses seam; branches outside window ignored
        run_case("R8 outside ignored", 32'h3B, 32'h3A, 32'h4B, NONE, 3'b111, 16'hFFFF, 32'h4B, 2'd0);
        // R6: taken branch before seam
        run_case("R6 first taken", 32'h3B, 32'h3E, NONE, NONE, 3'b001, 16'h000F, tgt_of(32'h3E), 2'd1);
        // R10: second branch taken
        run_case("R10 second taken", 32'h20, 32'h22, 32'h27, NONE, 3'b010, 16'h00FF, tgt_of(32'h27), 2'd2);
        // R7: three not-taken
        run_case("R7 three not taken", 32'h20, 32'h21, 32'h24, 32'h29, 3'b000, 16'h03FF, 32'h2A, 2'd3);
        // R10: third prediction applies to third branch
        run_case("R10 third taken", 32'h20, 32'h21, 32'h24, 32'h29, 3'b100, 16'h03FF, tgt_of(32'h29), 2'd3);
        run_case("R10 mid taken", 32'h20, 32'h21, 32'h24, 32'h29, 3'b010, 16'h001F, tgt_of(32'h24), 2'd2);
        // R6: taken in last slot, from following line
        run_case("R6 last slot", 32'h05, 32'h14, NONE, NONE, 3'b001, 16'hFFFF, tgt_of(32'h14), 2'd1);
        t_idle();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule